// File: doc/BRIEF.md
# DMA Channel Event and Interrupt Manager

This block sits beside the channel thread engines of a multi-channel DMA controller. It tracks a set of event flags that the threads share, and it turns selected events into level interrupts for a host processor. Each thread presents one command at a time over a valid/ready handshake. A command is either a send of an event, a wait for an event, or a write barrier. The block holds a thread back by dropping its ready, for as long as that thread is halted or stalled.

For each event, an enable register picks the route a send takes. With the bit clear, the send sets an internal flag, or it wakes a thread that is waiting on that event. With the bit set, the send raises the matching interrupt line instead. The interrupt line stays high until the host writes a one to the same bit of a clear register. A barrier stalls its thread until every bus write that thread has issued has been answered. A send placed behind the barrier therefore cannot signal completion early.

Handshake rules: a command is taken on a rising edge where both `cmd_valid` and `cmd_ready` of that thread are high. While `cmd_ready` is low, the thread must hold its command, and the held command has no effect.

Top module: `dma_event_irq_mgr`

## Requirements
- R1: After reset, every `cmd_ready` bit is 1, every `ev_stalled` bit is 0, every `irq_out` bit is 0 and all interrupt enables are 0.
- R2: A send on an event whose enable bit is clear, with no thread waiting on that event, leaves the event pending for any number of idle cycles, until a wait consumes it.
- R3: A wait taken while its event is pending drops that thread's `cmd_ready` for exactly one cycle, leaves `ev_stalled` low, and consumes the pending event.
- R4: A wait taken while its event is not pending raises `ev_stalled` and drops `cmd_ready` for that thread. Both stay that way until a send on that event is taken. The thread shows ready again in the cycle after that send is taken.
- R5: One send releases at most one thread. Among the threads already stalled on that event, the lowest-numbered one is released. If none is stalled, the lowest-numbered thread issuing a wait on that event in the same cycle takes the event, and the other waiters stall.
- R6: When a send and a wait on the same event are taken in the same cycle, the waiter gets the one-cycle halt of R3 and the event is left not pending.
- R7: With an event's enable bit set, a send on it drives that `irq_out` bit high in the next cycle. It sets no flag and wakes no waiter.
- R8: An `irq_out` bit falls only after a clear write with a one in that bit. Clear bits of other events and waits on the event leave it high. A send and a clear on the same bit in the same cycle leave it high.
- R9: Each thread counts its outstanding writes: `wr_issue` pulses add one and `wr_resp` pulses subtract one. A barrier keeps `cmd_ready` low until the cycle after the count is zero, so a barrier with nothing outstanding costs one cycle.
- R10: A command presented while `cmd_ready` is low has no effect. Thread t uses opcode bits [2t+1:2t] of `cmd_op` and event bits [4t+3:4t] of `cmd_event`. The opcodes are 0 for send, 1 for wait, 2 for barrier, and 3 for a no-op that is accepted and ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 8 | Per-thread command valid |
| cmd_op | input | 16 | Per-thread opcode, 2 bits each |
| cmd_event | input | 32 | Per-thread event number, 4 bits each |
| cmd_ready | output | 8 | Per-thread ready; low while halted or stalled |
| ev_stalled | output | 8 | Per-thread flag: stalled waiting for an event |
| wr_issue | input | 8 | Per-thread pulse: a bus write was issued |
| wr_resp | input | 8 | Per-thread pulse: a bus write response arrived |
| irq_en_wr | input | 1 | Write strobe for the interrupt enable register |
| irq_en_data | input | 16 | New value for the interrupt enable register |
| irq_clr_wr | input | 1 | Write strobe for the interrupt clear register |
| irq_clr_data | input | 16 | Write-one-to-clear mask for interrupt lines |
| irq_out | output | 16 | Active-high level interrupt per event |

## Verification
The flag path is driven with five patterns. A send followed by idle cycles and a late wait tells a held pending event from a lost one. A wait ahead of its send tells a true stall from a one-cycle halt. Three waiters on one event, released by three separate sends, show that each send frees only the lowest-numbered stalled thread. A send and a wait in the same cycle show that the event is consumed, and a later wait then stalls. The interrupt route is tried with a waiter on the same event, with clears of other bits and with a clear that collides with a send, which separates level holding from pulse behaviour. Outstanding writes ahead of a barrier, and a command held against a low ready, check that a stalled thread issues nothing.

// File: rtl/evirq_pkg.sv
package evirq_pkg;
  typedef enum logic [1:0] {
    OP_SEND    = 2'd0,
    OP_WAIT    = 2'd1,
    OP_BARRIER = 2'd2,
    OP_NONE    = 2'd3
  } cmd_op_e;

  typedef enum logic [1:0] {
    TH_RUN     = 2'd0,
    TH_HALT    = 2'd1,
    TH_EVWAIT  = 2'd2,
    TH_BARRIER = 2'd3
  } th_state_e;
endpackage

// File: rtl/evirq_thread.sv
module evirq_thread
  import evirq_pkg::*;
#(
  parameter int EV_W  = 4,
  parameter int CNT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [EV_W-1:0] cmd_event,
  input  logic            grant_old,
  input  logic            grant_new,
  input  logic            wr_issue,
  input  logic            wr_resp,
  output logic            cmd_ready,
  output logic            ev_waiting,
  output logic [EV_W-1:0] wait_event,
  output logic            acc_send,
  output logic            acc_wait
);
  th_state_e        state_q, state_d;
  logic [CNT_W-1:0] pend_wr;
  logic             acc;
  cmd_op_e          op;

  assign op        = cmd_op_e'(cmd_op);
  assign cmd_ready = (state_q == TH_RUN);
  assign acc       = cmd_valid && cmd_ready;
  assign acc_send  = acc && (op == OP_SEND);
  assign acc_wait  = acc && (op == OP_WAIT);
  assign ev_waiting = (state_q == TH_EVWAIT);

  // Outstanding-write count for the barrier
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pend_wr <= '0;
    else if (wr_issue && !wr_resp)  pend_wr <= pend_wr + 1'b1;
    else if (!wr_issue && wr_resp)  pend_wr <= pend_wr - 1'b1;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TH_RUN: begin
        if (acc && op == OP_WAIT)         state_d = grant_new ? TH_HALT : TH_EVWAIT;
        else if (acc && op == OP_BARRIER) state_d = TH_BARRIER;
      end
      TH_HALT:    state_d = TH_RUN;
      TH_EVWAIT:  if (grant_old) state_d = TH_RUN;
      TH_BARRIER: if (pend_wr == '0) state_d = TH_RUN;
      default:    state_d = TH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= TH_RUN;
      wait_event <= '0;
    end else begin
      state_q <= state_d;
      if (acc_wait) wait_event <= cmd_event;
    end
  end
endmodule

// File: rtl/evirq_event_arb.sv
module evirq_event_arb #(
  parameter int NT   = 8,
  parameter int NE   = 16,
  parameter int EV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NT-1:0]    acc_send,
  input  logic [NT-1:0]    acc_wait,
  input  logic [NT*EV_W-1:0] cmd_event,
  input  logic [NT-1:0]    ev_waiting,
  input  logic [NT*EV_W-1:0] wait_event,
  input  logic [NE-1:0]    irq_en,
  output logic [NT-1:0]    grant_old,
  output logic [NT-1:0]    grant_new,
  output logic [NE-1:0]    irq_set
);
  logic [NE-1:0] flag_q, flag_d, sent, avail, taken;
  logic [EV_W-1:0] ev;

  always_comb begin
    sent      = '0;
    taken     = '0;
    grant_old = '0;
    grant_new = '0;
    ev        = '0;
    for (int t = 0; t < NT; t++) begin
      if (acc_send[t]) sent[cmd_event[t*EV_W +: EV_W]] = 1'b1;
    end
    irq_set = sent & irq_en;
    avail   = flag_q | (sent & ~irq_en);
    // Threads already stalled have priority, lowest index first
    for (int t = 0; t < NT; t++) begin
      ev = wait_event[t*EV_W +: EV_W];
      if (ev_waiting[t] && avail[ev] && !taken[ev]) begin
        grant_old[t] = 1'b1;
        taken[ev]    = 1'b1;
      end
    end
    // Then waits issued in this cycle, lowest index first
    for (int t = 0; t < NT; t++) begin
      ev = cmd_event[t*EV_W +: EV_W];
      if (acc_wait[t] && avail[ev] && !taken[ev]) begin
        grant_new[t] = 1'b1;
        taken[ev]    = 1'b1;
      end
    end
    flag_d = avail & ~taken;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/evirq_irq_regs.sv
module evirq_irq_regs #(
  parameter int NE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_wr,
  input  logic [NE-1:0] en_data,
  input  logic          clr_wr,
  input  logic [NE-1:0] clr_data,
  input  logic [NE-1:0] irq_set,
  output logic [NE-1:0] irq_en,
  output logic [NE-1:0] irq_out
);
  logic [NE-1:0] clr_mask;
  assign clr_mask = clr_wr ? clr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en  <= '0;
      irq_out <= '0;
    end else begin
      if (en_wr) irq_en <= en_data;
      irq_out <= (irq_out & ~clr_mask) | irq_set;  // set wins over clear
    end
  end
endmodule

// File: rtl/dma_event_irq_mgr.sv
module dma_event_irq_mgr #(
  parameter int NT    = 8,
  parameter int NE    = 16,
  parameter int CNT_W = 4,
  localparam int EV_W = $clog2(NE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NT-1:0]    cmd_valid,
  input  logic [2*NT-1:0]  cmd_op,
  input  logic [NT*EV_W-1:0] cmd_event,
  output logic [NT-1:0]    cmd_ready,
  output logic [NT-1:0]    ev_stalled,
  input  logic [NT-1:0]    wr_issue,
  input  logic [NT-1:0]    wr_resp,
  input  logic             irq_en_wr,
  input  logic [NE-1:0]    irq_en_data,
  input  logic             irq_clr_wr,
  input  logic [NE-1:0]    irq_clr_data,
  output logic [NE-1:0]    irq_out
);
  logic [NT-1:0]      grant_old, grant_new, acc_send, acc_wait;
  logic [NT*EV_W-1:0] wait_event;
  logic [NE-1:0]      irq_en, irq_set;

  for (genvar t = 0; t < NT; t++) begin : g_thr
    evirq_thread #(.EV_W(EV_W), .CNT_W(CNT_W)) u_thr (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid[t]),
      .cmd_op     (cmd_op[2*t +: 2]),
      .cmd_event  (cmd_event[t*EV_W +: EV_W]),
      .grant_old  (grant_old[t]),
      .grant_new  (grant_new[t]),
      .wr_issue   (wr_issue[t]),
      .wr_resp    (wr_resp[t]),
      .cmd_ready  (cmd_ready[t]),
      .ev_waiting (ev_stalled[t]),
      .wait_event (wait_event[t*EV_W +: EV_W]),
      .acc_send   (acc_send[t]),
      .acc_wait   (acc_wait[t])
    );
  end

  evirq_event_arb #(.NT(NT), .NE(NE), .EV_W(EV_W)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_send   (acc_send),
    .acc_wait   (acc_wait),
    .cmd_event  (cmd_event),
    .ev_waiting (ev_stalled),
    .wait_event (wait_event),
    .irq_en     (irq_en),
    .grant_old  (grant_old),
    .grant_new  (grant_new),
    .irq_set    (irq_set)
  );

  evirq_irq_regs #(.NE(NE)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_wr    (irq_en_wr),
    .en_data  (irq_en_data),
    .clr_wr   (irq_clr_wr),
    .clr_data (irq_clr_data),
    .irq_set  (irq_set),
    .irq_en   (irq_en),
    .irq_out  (irq_out)
  );
endmodule

// File: rtl/evirq_checker.sv
module evirq_checker #(
  parameter int NT   = 8,
  parameter int NE   = 16,
  parameter int EV_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NT-1:0]      cmd_valid,
  input logic [2*NT-1:0]    cmd_op,
  input logic [NT*EV_W-1:0] cmd_event,
  input logic [NT-1:0]      cmd_ready,
  input logic [NT-1:0]      ev_stalled,
  input logic               irq_clr_wr,
  input logic [NE-1:0]      irq_clr_data,
  input logic [NE-1:0]      irq_out
);
  logic [NE-1:0] send_mask, clr_mask;
  logic [NT-1:0] wait_acc;

  assign clr_mask = irq_clr_wr ? irq_clr_data : '0;

  always_comb begin
    send_mask = '0;
    wait_acc  = '0;
    for (int t = 0; t < NT; t++) begin
      if (cmd_valid[t] && cmd_ready[t]) begin
        if (cmd_op[2*t +: 2] == 2'd0) send_mask[cmd_event[t*EV_W +: EV_W]] = 1'b1;
        if (cmd_op[2*t +: 2] == 2'd1) wait_acc[t] = 1'b1;
      end
    end
  end

  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((($past(irq_out) & ~$past(clr_mask)) & ~irq_out) == '0));

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((irq_out & ~$past(irq_out) & ~$past(send_mask)) == '0));

  assert_one_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ($countones($past(ev_stalled) & ~ev_stalled) <= $countones($past(send_mask))));

  for (genvar t = 0; t < NT; t++) begin : g_chk
    assert_stall_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ev_stalled[t]) |-> $past(wait_acc[t]));

    assert_stall_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stalled[t] |-> !cmd_ready[t]);
  end
endmodule

bind dma_event_irq_mgr evirq_checker #(.NT(NT), .NE(NE), .EV_W(EV_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_op       (cmd_op),
  .cmd_event    (cmd_event),
  .cmd_ready    (cmd_ready),
  .ev_stalled   (ev_stalled),
  .irq_clr_wr   (irq_clr_wr),
  .irq_clr_data (irq_clr_data),
  .irq_out      (irq_out)
);

// File: tb/sim_dma_event_irq_mgr.sv
`timescale 1ns/1ps
module sim_dma_event_irq_mgr;
  localparam int NT = 8;
  localparam int NE = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT-1:0] cmd_valid = '0;
  logic [15:0]   cmd_op = '1;
  logic [31:0]   cmd_event = '0;
  logic [NT-1:0] cmd_ready, ev_stalled;
  logic [NT-1:0] wr_issue = '0, wr_resp = '0;
  logic          irq_en_wr = 1'b0, irq_clr_wr = 1'b0;
  logic [NE-1:0] irq_en_data = '0, irq_clr_data = '0;
  logic [NE-1:0] irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dma_event_irq_mgr u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_event(cmd_event), .cmd_ready(cmd_ready), .ev_stalled(ev_stalled),
    .wr_issue(wr_issue), .wr_resp(wr_resp), .irq_en_wr(irq_en_wr),
    .irq_en_data(irq_en_data), .irq_clr_wr(irq_clr_wr),
    .irq_clr_data(irq_clr_data), .irq_out(irq_out)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(int t, logic [1:0] op, logic [3:0] ev);
    cmd_valid[t]       = 1'b1;
    cmd_op[2*t +: 2]   = op;
    cmd_event[4*t +: 4] = ev;
  endtask

  task automatic idle();
    cmd_valid = '0;
    cmd_op    = '1;
  endtask

  task automatic send_now(logic [3:0] ev);
    put(0, 2'd0, ev); tick(); idle();
  endtask

  task automatic test_reset();
    chk("R1 ready", 32'(cmd_ready), 32'hFF);
    chk("R1 stalled", 32'(ev_stalled), 32'h0);
    chk("R1 irq", 32'(irq_out), 32'h0);
  endtask

  task automatic test_pending();
    send_now(4'd6);
    tick(); tick();                          // R2: stays pending while idle
    put(4, 2'd1, 4'd6); tick(); idle();
    chk("R2 pending consumed, no stall", 32'(ev_stalled[4]), 32'h0);
    chk("R3 halt cycle", 32'(cmd_ready[4]), 32'h0);
    tick();
    chk("R3 resume after one cycle", 32'(cmd_ready[4]), 32'h1);
    put(3, 2'd1, 4'd6); tick(); idle();
    chk("R4 second waiter stalls", 32'({ev_stalled[3], cmd_ready[3]}), 32'h2);
    tick(); tick(); tick();
    chk("R4 still stalled", 32'(ev_stalled[3]), 32'h1);
    send_now(4'd6);
    chk("R4 released after send", 32'({ev_stalled[3], cmd_ready[3]}), 32'h1);
  endtask

  task automatic test_priority();
    put(5, 2'd1, 4'd9); put(6, 2'd1, 4'd9); put(2, 2'd1, 4'd9); tick(); idle();
    chk("R5 three stalled", 32'(ev_stalled), 32'h64);
    send_now(4'd9);
    chk("R5 lowest released first", 32'(ev_stalled), 32'h60);
    send_now(4'd9);
    chk("R5 next lowest", 32'(ev_stalled), 32'h40);
    send_now(4'd9);
    chk("R5 last released", 32'(ev_stalled), 32'h00);
    send_now(4'd10);
    put(3, 2'd1, 4'd10); put(1, 2'd1, 4'd10); tick(); idle();
    chk("R5 new waiters: lowest takes event", 32'({ev_stalled, cmd_ready[1]}), 32'h10);
    send_now(4'd10);
    chk("R5 cleanup", 32'(ev_stalled), 32'h0);
  endtask

  task automatic test_same_cycle();
    put(1, 2'd0, 4'd3); put(7, 2'd1, 4'd3); tick(); idle();
    chk("R6 halt one cycle", 32'({ev_stalled[7], cmd_ready[7]}), 32'h0);
    tick();
    chk("R6 resumed", 32'(cmd_ready[7]), 32'h1);
    put(6, 2'd1, 4'd3); tick(); idle();
    chk("R6 flag left clear", 32'(ev_stalled[6]), 32'h1);
    send_now(4'd3);
    chk("R6 cleanup", 32'(ev_stalled[6]), 32'h0);
  endtask

  task automatic test_irq();
    irq_en_wr = 1'b1; irq_en_data = 16'h0020; tick(); irq_en_wr = 1'b0;
    send_now(4'd5);
    chk("R7 irq raised", 32'(irq_out), 32'h20);
    put(2, 2'd1, 4'd5); tick(); idle();
    chk("R7 no flag set", 32'(ev_stalled[2]), 32'h1);
    chk("R8 wait keeps irq", 32'(irq_out), 32'h20);
    irq_clr_wr = 1'b1; irq_clr_data = 16'h0001; tick(); irq_clr_wr = 1'b0;
    chk("R8 other clear bit", 32'(irq_out), 32'h20);
    irq_clr_wr = 1'b1; irq_clr_data = 16'h0020; put(0, 2'd0, 4'd5); tick();
    irq_clr_wr = 1'b0; idle();
    chk("R8 set wins over clear", 32'(irq_out), 32'h20);
    irq_clr_wr = 1'b1; irq_clr_data = 16'h0020; tick(); irq_clr_wr = 1'b0;
    chk("R8 cleared", 32'(irq_out), 32'h0);
    irq_en_wr = 1'b1; irq_en_data = 16'h0; tick(); irq_en_wr = 1'b0;
    send_now(4'd5);
    chk("R7 flag route after disable", 32'(ev_stalled[2]), 32'h0);
  endtask

  task automatic test_barrier();
    wr_issue[2] = 1'b1; tick(); tick(); wr_issue[2] = 1'b0;
    put(2, 2'd2, 4'd0); tick(); idle();
    chk("R9 barrier stalls", 32'(cmd_ready[2]), 32'h0);
    tick();
    wr_resp[2] = 1'b1; tick(); wr_resp[2] = 1'b0;
    chk("R9 one write left", 32'(cmd_ready[2]), 32'h0);
    wr_resp[2] = 1'b1; tick(); wr_resp[2] = 1'b0;
    chk("R9 count just zero", 32'(cmd_ready[2]), 32'h0);
    tick();
    chk("R9 resumed", 32'(cmd_ready[2]), 32'h1);
    put(5, 2'd2, 4'd0); tick(); idle();
    chk("R9 empty barrier one cycle", 32'(cmd_ready[5]), 32'h0);
    tick();
    chk("R9 empty barrier resumed", 32'(cmd_ready[5]), 32'h1);
  endtask

  task automatic test_backpressure();
    irq_en_wr = 1'b1; irq_en_data = 16'h1000; tick(); irq_en_wr = 1'b0;
    put(4, 2'd1, 4'd11); tick(); idle();
    put(4, 2'd0, 4'd12);
    tick(); tick(); tick();
    chk("R10 held send ignored", 32'(irq_out), 32'h0);
    idle();
    put(0, 2'd3, 4'd11); tick(); idle();
    chk("R10 no-op wakes nothing", 32'(ev_stalled[4]), 32'h1);
    send_now(4'd11);
    chk("R10 released", 32'(ev_stalled[4]), 32'h0);
    irq_en_wr = 1'b1; irq_en_data = 16'h0; tick(); irq_en_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_pending();
    test_priority();
    test_same_cycle();
    test_irq();
    test_barrier();
    test_backpressure();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule